// File: doc/BRIEF.md
# Setup-Through-FIFO Vertex Memory Bridge

This block sits between a shader processor and a small per-vertex word memory. Traffic in each direction passes through its own four-entry queue of 32-bit words. Each word the processor pushes into the outbound queue carries a sideband flag that marks it as a setup command or as plain data. Setup commands therefore travel in order with the data. A command takes effect in the cycle it leaves the queue, and it programs either the read channel or the write channel.

A read setup loads a start address and a word count into the read engine. The engine then fetches consecutive words from the memory into the inbound queue without waiting for the processor. It stops when the queue is full and resumes as the processor pops words. A write setup loads a write pointer. Each later data word is stored at that pointer, and the pointer then steps by one. A new read setup replaces the active one at once, even if words from the old setup are still pending. Software must therefore drain one read group completely before it issues the next one.

Both processor-side interfaces use valid/ready. A push is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. A pop is accepted on an edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value. When the inbound queue is empty, `rd_valid` is low, so the processor stalls and never sees stale data.

Top module: `vtx_bridge`

## Requirements
- R1: After reset, both queues are empty and both setup channels are invalid: `rd_valid` is 0 and `wr_ready` is 1.
- R2: The inbound queue holds at most 4 words, and the engine stops fetching while it is full. No word is lost or duplicated. While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` stays stable.
- R3: A word pushed with `wr_is_setup`=1 and bit 31 = 0 is a write setup. It loads the write pointer from bits [ADDR_W-1:0]. Each later word pushed with `wr_is_setup`=0 is stored at the pointer, and the pointer then increments by one modulo the memory depth. Words are handled in push order.
- R4: A word pushed with `wr_is_setup`=1 and bit 31 = 1 is a read setup. Its start address is bits [ADDR_W-1:0], and its count is bits [23:20], where a field value of 0 means 16. The words at consecutive addresses, wrapping modulo the depth, are delivered in order. All other setup bits are ignored; the usual pattern is 0x1A00.
- R5: After a read setup's count of words has been delivered, `rd_valid` stays 0 until another read setup arrives.
- R6: A data word that arrives while no write setup has been received since reset is dropped, and the memory is left unchanged.
- R7: A read setup replaces the active one immediately. Words already in the inbound queue are still delivered. The unfetched rest of the old group is never delivered. The new group follows.
- R8: If no read setup has been received since reset, `rd_valid` never rises, even when data words are pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Outbound push request |
| wr_ready | output | 1 | Outbound queue has room |
| wr_is_setup | input | 1 | Sideband flag: the pushed word is a setup command |
| wr_data | input | 32 | Pushed data or setup word |
| rd_valid | output | 1 | Inbound queue holds a word |
| rd_ready | input | 1 | Processor takes the head word |
| rd_data | output | 32 | Head word of the inbound queue |

## Verification
A read pointer that is off by one, or a count that is decoded wrongly, shows up in the very next popped word as a wrong value. It can also show up as one word too many or too few once the group drains, which is within a few cycles. A setup that is applied late or early changes how many old words appear before the new group. That count is checked exactly, with the engine stalled by a full queue. A write path that ignores the missing-setup state corrupts memory silently, so that fault is exposed only by reading the affected addresses back after a mid-run reset.

// File: rtl/vb_pkg.sv
package vb_pkg;
  localparam int WORD_W   = 32;
  localparam int CNT_LSB  = 20;
  localparam int CNT_W    = 4;
  localparam int KIND_BIT = 31;

  // Field value zero encodes the maximum group size.
  function automatic logic [CNT_W:0] setup_count(input logic [WORD_W-1:0] w);
    logic [CNT_W-1:0] f;
    f = w[CNT_LSB +: CNT_W];
    return (f == '0) ? (CNT_W+1)'(1 << CNT_W) : {1'b0, f};
  endfunction
endpackage

// File: rtl/vb_fifo.sv
module vb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;

  assign dout = store[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (int'(wp) == DEPTH-1) ? '0 : wp + 1'b1;
      if (pop)  rp <= (int'(rp) == DEPTH-1) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end
endmodule

// File: rtl/vb_ram.sv
module vb_ram #(
  parameter int AW = 6,
  parameter int W  = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/vb_read_engine.sv
module vb_read_engine import vb_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W:0]    load_cnt,
  input  logic [CW-1:0]     fifo_count,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              fill,
  output logic              active,
  output logic [CNT_W:0]    left
);
  localparam logic [CW:0] LIMIT = (CW+1)'(DEPTH);

  logic [ADDR_W-1:0] addr;
  logic              pend;
  logic              room;

  // Count the word still in flight from memory so the queue never overflows.
  assign room     = ({1'b0, fifo_count} + {{CW{1'b0}}, pend}) < LIMIT;
  assign ram_re   = active && (left != '0) && room;
  assign ram_addr = addr;
  assign fill     = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      left   <= '0;
      addr   <= '0;
      pend   <= 1'b0;
    end else begin
      pend <= ram_re;
      if (load) begin
        active <= 1'b1;
        left   <= load_cnt;
        addr   <= load_addr;
      end else if (ram_re) begin
        left <= left - 1'b1;
        addr <= addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vtx_bridge.sv
module vtx_bridge import vb_pkg::*; #(
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_is_setup,
  input  logic [WORD_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  // Outbound queue: setup flag travels beside each word.
  logic [CW-1:0]     wf_count;
  logic [WORD_W:0]   wf_head;
  logic              wf_push, wf_pop;
  logic              head_setup;
  logic [WORD_W-1:0] head_word;

  assign wr_ready   = (int'(wf_count) != FIFO_DEPTH);
  assign wf_push    = wr_valid && wr_ready;
  assign wf_pop     = (wf_count != '0);
  assign head_setup = wf_head[WORD_W];
  assign head_word  = wf_head[WORD_W-1:0];

  vb_fifo #(.W(WORD_W+1), .DEPTH(FIFO_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n),
    .push(wf_push), .din({wr_is_setup, wr_data}),
    .pop(wf_pop), .dout(wf_head), .count(wf_count)
  );

  // Far end of the outbound queue: setups take effect as they leave.
  logic              rd_load, ws_load, data_out;
  logic              ws_valid;
  logic [ADDR_W-1:0] ws_addr;
  logic              ram_we;

  assign rd_load  = wf_pop && head_setup &&  head_word[KIND_BIT];
  assign ws_load  = wf_pop && head_setup && !head_word[KIND_BIT];
  assign data_out = wf_pop && !head_setup;
  assign ram_we   = data_out && ws_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_valid <= 1'b0;
      ws_addr  <= '0;
    end else if (ws_load) begin
      ws_valid <= 1'b1;
      ws_addr  <= head_word[ADDR_W-1:0];
    end else if (ram_we) begin
      ws_addr  <= ws_addr + 1'b1;
    end
  end

  // Read engine and memory.
  logic              eng_re, eng_fill, eng_active;
  logic [ADDR_W-1:0] eng_addr;
  logic [CNT_W:0]    eng_left;
  logic [WORD_W-1:0] ram_q;
  logic [CW-1:0]     rf_count;
  logic              rf_pop;

  vb_read_engine #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .load(rd_load), .load_addr(head_word[ADDR_W-1:0]),
    .load_cnt(setup_count(head_word)), .fifo_count(rf_count),
    .ram_re(eng_re), .ram_addr(eng_addr), .fill(eng_fill),
    .active(eng_active), .left(eng_left)
  );

  vb_ram #(.AW(ADDR_W), .W(WORD_W)) u_mem (
    .clk(clk),
    .we(ram_we), .waddr(ws_addr), .wdata(head_word),
    .re(eng_re), .raddr(eng_addr), .rdata(ram_q)
  );

  // Inbound queue towards the processor.
  assign rd_valid = (rf_count != '0);
  assign rf_pop   = rd_valid && rd_ready;

  vb_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n),
    .push(eng_fill), .din(ram_q),
    .pop(rf_pop), .dout(rd_data), .count(rf_count)
  );
endmodule

// File: rtl/vtx_bridge_chk.sv
module vtx_bridge_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [31:0]   rd_data,
  input logic          fill,
  input logic [CW-1:0] rf_count,
  input logic          issue,
  input logic          active,
  input logic [LW-1:0] left,
  input logic          load,
  input logic          ram_we,
  input logic          ws_valid
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> (int'(rf_count) < DEPTH) || (rd_valid && rd_ready));

  p_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rf_count) <= DEPTH);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !load |=> left == $past(left) - 1'b1);

  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (left == '0) && !load |=> !issue);

  p_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ws_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !rd_valid || $past(issue) || $past(rd_valid));
endmodule

bind vtx_bridge vtx_bridge_chk #(.DEPTH(FIFO_DEPTH), .CW(CW), .LW(vb_pkg::CNT_W+1)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .fill(eng_fill), .rf_count(rf_count),
  .issue(eng_re), .active(eng_active), .left(eng_left), .load(rd_load),
  .ram_we(ram_we), .ws_valid(ws_valid)
);

// File: tb/sim_vtx_bridge.sv
`timescale 1ns/1ps
module sim_vtx_bridge;
  localparam int AW = 6;
  localparam int MD = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_is_setup = 1'b0, rd_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, rd_valid;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  vtx_bridge #(.ADDR_W(AW), .FIFO_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_is_setup(wr_is_setup), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] model [MD];
  logic [31:0] got [64];
  int ngot;

  function automatic logic [31:0] rsetup(int a, int n);
    return 32'h8000_0000 | (32'(n & 15) << 20) | 32'h1A00 | 32'(a % MD);
  endfunction
  function automatic logic [31:0] wsetup(int a);
    return 32'h1A00 | 32'(a % MD);
  endfunction
  function automatic int group_len(int n);
    return ((n & 15) == 0) ? 16 : (n & 15);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(bit s, logic [31:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_is_setup = s; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_is_setup = 1'b0;
  endtask

  task automatic write_block(int a, int n);
    push(1'b1, wsetup(a));
    for (int i = 0; i < n; i++) begin
      logic [31:0] v;
      v = $urandom;
      model[(a + i) % MD] = v;
      push(1'b0, v);
    end
  endtask

  task automatic collect(bit rnd);
    int idle;
    ngot = 0; idle = 0;
    while (idle < 40) begin
      @(negedge clk);
      rd_ready = rnd ? 1'($urandom % 2) : 1'b1;
      if (rd_valid && rd_ready && ngot < 64) begin
        got[ngot] = rd_data; ngot++; idle = 0;
      end else idle++;
    end
    rd_ready = 1'b0;
  endtask

  task automatic read_check(int a, int field, bit rnd, string tag);
    int n;
    n = group_len(field);
    push(1'b1, rsetup(a, field));
    collect(rnd);
    chk(ngot == n, {tag, " count"}, 32'(ngot), 32'(n));
    for (int i = 0; i < n && i < ngot; i++)
      chk(got[i] == model[(a + i) % MD], tag, got[i], model[(a + i) % MD]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    do_reset();
    // R1: reset state
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
    chk(wr_ready == 1'b1, "R1 wr_ready", 32'(wr_ready), 1);

    // R8: data with no setup at all never produces output
    for (int i = 0; i < 3; i++) push(1'b0, 32'hDEAD_0000 + 32'(i));
    repeat (20) @(negedge clk);
    chk(rd_valid == 1'b0, "R8 no read setup", 32'(rd_valid), 0);

    // R3/R4: fill memory, then read a 16-word group (field 0)
    write_block(0, MD);
    read_check(0, 0, 1'b0, "R4 field0=16");
    // R5: nothing more once the group is drained
    repeat (20) @(negedge clk);
    chk(rd_valid == 1'b0, "R5 idle after group", 32'(rd_valid), 0);

    // R4: wrap around the top of memory
    read_check(MD - 3, 7, 1'b1, "R4 wrap");

    // R2: backpressure with processor not popping
    push(1'b1, rsetup(20, 10));
    repeat (30) @(negedge clk);
    chk(rd_valid == 1'b1, "R2 held words", 32'(rd_valid), 1);
    collect(1'b1);
    chk(ngot == 10, "R2 count", 32'(ngot), 10);
    for (int i = 0; i < 10 && i < ngot; i++)
      chk(got[i] == model[20 + i], "R2 order", got[i], model[20 + i]);

    // R6: after reset, data without write setup must not alter memory
    do_reset();
    for (int i = 0; i < 4; i++) push(1'b0, 32'hBAD0_0000 + 32'(i));
    read_check(0, 4, 1'b0, "R6 unchanged");

    // R3: write pointer increments from a new setup; random mix
    for (int it = 0; it < 24; it++) begin
      int wa, wn, ra, rf;
      wa = int'($urandom % MD); wn = 1 + int'($urandom % 8);
      write_block(wa, wn);
      ra = ((it % 2) == 0) ? wa : int'($urandom % MD);
      rf = int'($urandom % 16);
      read_check(ra, rf, 1'(it % 2), "R3 random");
    end

    // R7: second read setup while the first group is stalled
    push(1'b1, rsetup(0, 0));
    repeat (12) @(negedge clk);
    push(1'b1, rsetup(40, 3));
    repeat (12) @(negedge clk);
    collect(1'b0);
    chk(ngot == 7, "R7 count", 32'(ngot), 7);
    for (int i = 0; i < 4 && i < ngot; i++)
      chk(got[i] == model[i], "R7 old prefix", got[i], model[i]);
    for (int i = 4; i < 7 && i < ngot; i++)
      chk(got[i] == model[36 + i], "R7 new group", got[i], model[36 + i]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule